// File: doc/BRIEF.md
# Dataflow Thread Synchronization Scheduler

This block holds a small table of pending dataflow threads. A requester asks for a new thread by giving a start instruction pointer and a synchronization count. The block then reserves a table entry and a frame in a fixed frame region, and answers with the frame pointer. Producers then write data into that frame. Each write names the frame pointer and a word offset. Each accepted write lowers the owning thread's count by one and emits the target word address. Once a count reaches zero, the thread joins a ready queue and is offered on a valid/ready dispatch port, carrying its instruction pointer and frame pointer. A running thread returns its entry and frame with a destroy request.

The frame region is cut into one fixed slot per table entry. Each slot is `SLOT_WORDS` words long and starts at `FRAME_BASE + index * SLOT_WORDS`. A request whose count exceeds the slot size cannot be placed. Requests are gated by a zero-flag input, so software can issue them conditionally. All responses are registered and appear one clock after the request.

Top module: `dfsync_sched`

## Requirements
- R1: After reset no dispatch is offered, no schedule or write response is raised, and every table entry is free.
- R2: A schedule request with `sched_zf`=1 and `sched_cnt` ≤ `SLOT_WORDS` takes the lowest-numbered free entry i. One cycle later it raises `sched_ack` with `sched_fp` = `FRAME_BASE` + i·`SLOT_WORDS`.
- R3: A schedule request with `sched_zf`=0 raises neither `sched_ack` nor `sched_err` and reserves nothing, so the next accepted request gets the same entry.
- R4: A schedule request with `sched_zf`=1 and no free entry, or with `sched_cnt` > `SLOT_WORDS`, raises `sched_err` one cycle later and reserves nothing.
- R5: A frame write to the frame pointer of a waiting thread lowers that thread's count by one. One cycle later it raises `wr_addr_valid` with `wr_addr` = `wr_fp` + `wr_off` and `wr_data_o` = `wr_data`.
- R6: A thread is offered on dispatch only once its count has reached zero. The offer starts the cycle after the write that brought the count to zero and carries the thread's instruction pointer and frame pointer.
- R7: A schedule request accepted with `sched_cnt`=0 makes that thread offered for dispatch on the next cycle.
- R8: A frame write whose pointer matches no waiting thread changes no count. This covers unknown pointers and threads already ready or running. One cycle later it raises `wr_err` and leaves `wr_addr_valid` low.
- R9: Ready threads are offered one at a time, in the order in which their counts reached zero. The offer holds steady while `disp_ready` is low, and a thread leaves the queue when `disp_valid` and `disp_ready` are both high at a clock edge.
- R10: A destroy request naming a dispatched thread's frame pointer frees its entry for reuse. A destroy naming a thread that is still waiting or ready has no effect.
- R11: A frame write and a schedule request in the same cycle are both carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Schedule request strobe |
| sched_zf | input | 1 | Zero-flag gate; request acts only when 1 |
| sched_ip | input | IP_W (32) | Start instruction pointer of the new thread |
| sched_cnt | input | CNT_W (6) | Synchronization count and frame size in words |
| sched_ack | output | 1 | Schedule accepted (one cycle after request) |
| sched_err | output | 1 | Schedule refused: table full or frame too large |
| sched_fp | output | FP_W (16) | Frame pointer of the accepted thread |
| wr_valid | input | 1 | Frame write strobe |
| wr_fp | input | FP_W (16) | Frame pointer addressed by the write |
| wr_off | input | OFF_W (4) | Word offset inside the frame |
| wr_data | input | DATA_W (32) | Write data |
| wr_addr_valid | output | 1 | Accepted write: address and data valid |
| wr_addr | output | FP_W (16) | Target word address, frame pointer plus offset |
| wr_data_o | output | DATA_W (32) | Data of the accepted write |
| wr_err | output | 1 | Write matched no waiting thread |
| destroy_valid | input | 1 | Destroy request strobe |
| destroy_fp | input | FP_W (16) | Frame pointer of the thread to free |
| disp_valid | output | 1 | A ready thread is offered |
| disp_ready | input | 1 | Consumer takes the offered thread |
| disp_ip | output | IP_W (32) | Instruction pointer of the offered thread |
| disp_fp | output | FP_W (16) | Frame pointer of the offered thread |

## Verification
On every cycle, the assertions check these rules:
- a zero-flag-low request never produces a response;
- acceptance and refusal are never raised together;
- at most one entry matches a frame pointer;
- an unmatched write always comes back as an error;
- the offered thread is in the ready state;
- a zero-count thread is offered on the next cycle;
- a stalled offer stays unchanged.

Other behaviours can only be shown by the bench's scenarios, because they depend on history across many requests:
- the exact frame pointer chosen;
- reuse of a destroyed slot;
- the order in which ready threads come out;
- that a destroy aimed at a non-running thread is ignored;
- that a count is left untouched by a rejected write.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2,
    ST_RUN   = 2'd3
  } ent_state_e;

  // Start address of the frame slot owned by table entry idx.
  function automatic logic [31:0] slot_addr(logic [31:0] base, int unsigned idx,
                                            int unsigned words);
    return base + 32'(idx * words);
  endfunction

  // Pointer advance with wrap for a ring of the given depth.
  function automatic int unsigned ring_adv(int unsigned p, int unsigned k,
                                           int unsigned depth);
    return (p + k) % depth;
  endfunction

endpackage

// File: rtl/dfs_alloc.sv
// Lowest-index free entry picker.
module dfs_alloc #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     free_vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dfs_match.sv
// Associative compare of a frame pointer against every live entry.
module dfs_match #(
  parameter int N     = 8,
  parameter int FP_W  = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][FP_W-1:0] fps,
  input  logic [N-1:0]           live,
  input  logic [FP_W-1:0]        key,
  output logic [N-1:0]           hits,
  output logic                   any,
  output logic [IDX_W-1:0]       idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = live[g] && (fps[g] == key);
  end

  assign any = |hits;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dfs_ready_fifo.sv
// Ring of entry indices in the order their counts reached zero.
// Two push ports per cycle: port a is queued ahead of port b.
module dfs_ready_fifo #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [IDX_W-1:0] data_a,
  input  logic             push_b,
  input  logic [IDX_W-1:0] data_b,
  input  logic             pop,
  output logic             nonempty,
  output logic [IDX_W-1:0] head
);
  import dfs_pkg::*;

  localparam int CW = $clog2(N + 1);

  logic [IDX_W-1:0] mem_q [N];
  logic [IDX_W-1:0] wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic [IDX_W-1:0] wp_b;

  assign wp_b     = push_a ? IDX_W'(ring_adv(int'(wp_q), 1, N)) : wp_q;
  assign nonempty = (cnt_q != '0);
  assign head     = mem_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else begin
      if (push_a) mem_q[wp_q] <= data_a;
      if (push_b) mem_q[wp_b] <= data_b;
      wp_q  <= IDX_W'(ring_adv(int'(wp_q), 32'(push_a) + 32'(push_b), N));
      if (pop) rp_q <= IDX_W'(ring_adv(int'(rp_q), 1, N));
      cnt_q <= cnt_q + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end

  // Each entry is queued at most once, so the ring can never overfill.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) + 32'(push_a) + 32'(push_b) - 32'(pop)) <= 32'(N));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/dfsync_sched.sv
module dfsync_sched #(
  parameter int          N_ENT      = 8,
  parameter int          IP_W       = 32,
  parameter int          FP_W       = 16,
  parameter int          CNT_W      = 6,
  parameter int          DATA_W     = 32,
  parameter int          SLOT_WORDS = 16,
  parameter logic [31:0] FRAME_BASE = 32'h0000_1000,
  localparam int         OFF_W      = (SLOT_WORDS > 1) ? $clog2(SLOT_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_valid,
  input  logic              sched_zf,
  input  logic [IP_W-1:0]   sched_ip,
  input  logic [CNT_W-1:0]  sched_cnt,
  output logic              sched_ack,
  output logic              sched_err,
  output logic [FP_W-1:0]   sched_fp,
  input  logic              wr_valid,
  input  logic [FP_W-1:0]   wr_fp,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_addr_valid,
  output logic [FP_W-1:0]   wr_addr,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_err,
  input  logic              destroy_valid,
  input  logic [FP_W-1:0]   destroy_fp,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [IP_W-1:0]   disp_ip,
  output logic [FP_W-1:0]   disp_fp
);
  import dfs_pkg::*;

  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  // Entry table
  ent_state_e                   st_q [N_ENT];
  logic [N_ENT-1:0][IP_W-1:0]   ip_q;
  logic [N_ENT-1:0][FP_W-1:0]   fp_q;
  logic [N_ENT-1:0][CNT_W-1:0]  cnt_q;

  logic [N_ENT-1:0] free_vec, wait_vec, run_vec;
  for (genvar g = 0; g < N_ENT; g++) begin : g_state
    assign free_vec[g] = (st_q[g] == ST_FREE);
    assign wait_vec[g] = (st_q[g] == ST_WAIT);
    assign run_vec[g]  = (st_q[g] == ST_RUN);
  end

  // Named internal events
  logic             sched_go, too_big, alloc_found, alloc_ok, sched_zero;
  logic [IDX_W-1:0] alloc_idx;
  logic [N_ENT-1:0] wr_hits, dst_hits;
  logic             wr_any, dst_any, wr_hit, wr_to_zero, dst_hit, disp_pop;
  logic [IDX_W-1:0] wr_idx, dst_idx, head_idx;
  logic [FP_W-1:0]  alloc_fp;

  assign sched_go   = sched_valid && sched_zf;
  assign too_big    = (sched_cnt > CNT_W'(SLOT_WORDS));
  assign alloc_ok   = sched_go && alloc_found && !too_big;
  assign sched_zero = (sched_cnt == '0);
  assign alloc_fp   = FP_W'(slot_addr(FRAME_BASE, 32'(alloc_idx), SLOT_WORDS));

  dfs_alloc #(.N(N_ENT), .IDX_W(IDX_W)) alloc_i (
    .free_vec (free_vec),
    .found    (alloc_found),
    .idx      (alloc_idx)
  );

  dfs_match #(.N(N_ENT), .FP_W(FP_W), .IDX_W(IDX_W)) wr_match_i (
    .fps  (fp_q),
    .live (wait_vec),
    .key  (wr_fp),
    .hits (wr_hits),
    .any  (wr_any),
    .idx  (wr_idx)
  );

  dfs_match #(.N(N_ENT), .FP_W(FP_W), .IDX_W(IDX_W)) dst_match_i (
    .fps  (fp_q),
    .live (run_vec),
    .key  (destroy_fp),
    .hits (dst_hits),
    .any  (dst_any),
    .idx  (dst_idx)
  );

  assign wr_hit     = wr_valid && wr_any;
  assign wr_to_zero = wr_hit && (cnt_q[wr_idx] == CNT_W'(1));
  assign dst_hit    = destroy_valid && dst_any;
  assign disp_pop   = disp_valid && disp_ready;

  dfs_ready_fifo #(.N(N_ENT), .IDX_W(IDX_W)) rdy_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_a   (wr_to_zero),
    .data_a   (wr_idx),
    .push_b   (alloc_ok && sched_zero),
    .data_b   (alloc_idx),
    .pop      (disp_pop),
    .nonempty (disp_valid),
    .head     (head_idx)
  );

  assign disp_ip = ip_q[head_idx];
  assign disp_fp = fp_q[head_idx];

  // Table update: the four actions target entries in four distinct
  // states, so at most one of them touches a given entry per cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        st_q[i]  <= ST_FREE;
        ip_q[i]  <= '0;
        fp_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (alloc_ok && alloc_idx == IDX_W'(i)) begin
          st_q[i]  <= sched_zero ? ST_READY : ST_WAIT;
          ip_q[i]  <= sched_ip;
          fp_q[i]  <= alloc_fp;
          cnt_q[i] <= sched_cnt;
        end
        if (wr_hit && wr_idx == IDX_W'(i)) begin
          cnt_q[i] <= cnt_q[i] - CNT_W'(1);
          if (wr_to_zero) st_q[i] <= ST_READY;
        end
        if (disp_pop && head_idx == IDX_W'(i)) st_q[i] <= ST_RUN;
        if (dst_hit && dst_idx == IDX_W'(i)) st_q[i] <= ST_FREE;
      end
    end
  end

  // Registered responses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched_ack     <= 1'b0;
      sched_err     <= 1'b0;
      sched_fp      <= '0;
      wr_addr_valid <= 1'b0;
      wr_addr       <= '0;
      wr_data_o     <= '0;
      wr_err        <= 1'b0;
    end else begin
      sched_ack     <= alloc_ok;
      sched_err     <= sched_go && !(alloc_found && !too_big);
      if (alloc_ok) sched_fp <= alloc_fp;
      wr_addr_valid <= wr_hit;
      wr_err        <= wr_valid && !wr_hit;
      if (wr_hit) begin
        wr_addr   <= wr_fp + FP_W'(wr_off);
        wr_data_o <= wr_data;
      end
    end
  end

  // Assertions
  assert_zf_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_valid && !sched_zf) |=> (!sched_ack && !sched_err));

  assert_ack_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sched_ack && sched_err));

  assert_unique_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hits) && $onehot0(dst_hits));

  assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_any) |=> (wr_err && !wr_addr_valid));

  assert_offer_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (st_q[head_idx] == ST_READY));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && sched_zero) |=> disp_valid);

  assert_offer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=>
      (disp_valid && $stable(disp_fp) && $stable(disp_ip)));
endmodule

// File: tb/dfsync_sched_tb_top.sv
module dfsync_sched_tb_top;
  localparam int FP_W = 16;
  localparam int SLOT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sched_valid = 0, sched_zf = 0;
  logic [31:0] sched_ip = '0;
  logic [5:0]  sched_cnt = '0;
  logic        sched_ack, sched_err;
  logic [15:0] sched_fp;
  logic        wr_valid = 0;
  logic [15:0] wr_fp = '0;
  logic [3:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic        wr_addr_valid, wr_err;
  logic [15:0] wr_addr;
  logic [31:0] wr_data_o;
  logic        destroy_valid = 0;
  logic [15:0] destroy_fp = '0;
  logic        disp_valid, disp_ready = 0;
  logic [31:0] disp_ip;
  logic [15:0] disp_fp;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct packed { logic [31:0] ip; logic [15:0] fp; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  dfsync_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .sched_valid(sched_valid), .sched_zf(sched_zf), .sched_ip(sched_ip),
    .sched_cnt(sched_cnt), .sched_ack(sched_ack), .sched_err(sched_err),
    .sched_fp(sched_fp), .wr_valid(wr_valid), .wr_fp(wr_fp), .wr_off(wr_off),
    .wr_data(wr_data), .wr_addr_valid(wr_addr_valid), .wr_addr(wr_addr),
    .wr_data_o(wr_data_o), .wr_err(wr_err), .destroy_valid(destroy_valid),
    .destroy_fp(destroy_fp), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_ip(disp_ip), .disp_fp(disp_fp)
  );

  function automatic logic [15:0] fp_exp(int idx);
    return 16'h1000 + 16'(idx * SLOT);
  endfunction

  task automatic chk(bit ok, string req, logic [47:0] act, logic [47:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: request at a falling edge, results sampled 5 ns after the next one.
  task automatic sched(logic zf, logic [31:0] ip, logic [5:0] cnt);
    @(negedge clk);
    sched_valid = 1; sched_zf = zf; sched_ip = ip; sched_cnt = cnt;
    @(negedge clk);
    sched_valid = 0; sched_zf = 0;
    #5;
  endtask

  task automatic fwrite(logic [15:0] fp, logic [3:0] off, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_fp = fp; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    #5;
  endtask

  task automatic destroy(logic [15:0] fp);
    @(negedge clk);
    destroy_valid = 1; destroy_fp = fp;
    @(negedge clk);
    destroy_valid = 0;
    #5;
  endtask

  task automatic expect_ack(string req, int idx);
    chk(sched_ack && !sched_err && sched_fp == fp_exp(idx), req,
        {sched_ack, sched_err, sched_fp}, {1'b1, 1'b0, fp_exp(idx)});
  endtask

  // Monitor: scoreboard of dispatched threads, compared on each handshake.
  always begin
    @(negedge clk);
    #5;
    if (rst_n && disp_valid && disp_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9 unexpected dispatch", {disp_ip, disp_fp}, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(disp_ip == e.ip && disp_fp == e.fp, "R6/R9 dispatch order",
            {disp_ip, disp_fp}, {e.ip, e.fp});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", '0, '1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    // R1: reset state
    chk(!disp_valid && !sched_ack && !sched_err && !wr_err && !wr_addr_valid,
        "R1 reset outputs", {disp_valid, sched_ack, sched_err, wr_err}, '0);

    // R2: first allocation takes entry 0
    sched(1, 32'h100, 2);   expect_ack("R2 first alloc", 0);
    // R3: zero flag low -> ignored
    sched(0, 32'h999, 1);
    chk(!sched_ack && !sched_err, "R3 zf low no response", {sched_ack, sched_err}, '0);
    sched(1, 32'h200, 1);   expect_ack("R3 next alloc reuses entry 1", 1);
    chk(!disp_valid, "R6 not offered while counts nonzero", disp_valid, 0);
    // R7: zero count ready next cycle
    sched(1, 32'h300, 0);   expect_ack("R7 zero-count alloc", 2);
    exp_q.push_back({32'h300, fp_exp(2)});
    chk(disp_valid && disp_fp == fp_exp(2), "R7 offered next cycle",
        {disp_valid, disp_fp}, {1'b1, fp_exp(2)});

    // R5: write to waiting thread
    fwrite(fp_exp(0), 4'd3, 32'hCAFE);
    chk(wr_addr_valid && !wr_err && wr_addr == fp_exp(0) + 16'd3 && wr_data_o == 32'hCAFE,
        "R5 write address", {wr_addr_valid, wr_addr, wr_data_o},
        {1'b1, fp_exp(0) + 16'd3, 32'hCAFE});
    // R8: unknown pointer, and pointer of a ready thread
    fwrite(16'h0F00, 4'd0, 32'h1);
    chk(wr_err && !wr_addr_valid, "R8 unknown fp", {wr_err, wr_addr_valid}, 2'b10);
    fwrite(fp_exp(2), 4'd0, 32'h2);
    chk(wr_err && !wr_addr_valid, "R8 ready thread fp", {wr_err, wr_addr_valid}, 2'b10);

    // R11: write (B to zero) and schedule D in the same cycle
    @(negedge clk);
    wr_valid = 1; wr_fp = fp_exp(1); wr_off = 4'd0; wr_data = 32'h5;
    sched_valid = 1; sched_zf = 1; sched_ip = 32'h400; sched_cnt = 1;
    @(negedge clk);
    wr_valid = 0; sched_valid = 0; sched_zf = 0;
    #5;
    exp_q.push_back({32'h200, fp_exp(1)});
    chk(wr_addr_valid && sched_ack && sched_fp == fp_exp(3), "R11 both processed",
        {wr_addr_valid, sched_ack, sched_fp}, {1'b1, 1'b1, fp_exp(3)});

    // A to zero: count was lowered exactly once earlier (R8 writes changed nothing)
    fwrite(fp_exp(0), 4'd1, 32'h6);
    exp_q.push_back({32'h100, fp_exp(0)});
    // R9: offer holds while stalled
    repeat (3) @(negedge clk);
    #5;
    chk(disp_valid && disp_fp == fp_exp(2) && disp_ip == 32'h300, "R9 stalled head stable",
        {disp_ip, disp_fp}, {32'h300, fp_exp(2)});
    // R10: destroy of a ready (not dispatched) thread is ignored
    destroy(fp_exp(1));
    chk(disp_valid, "R10 destroy of ready thread ignored", disp_valid, 1);

    @(negedge clk);
    disp_ready = 1;
    repeat (6) @(negedge clk);
    #5;
    chk(exp_q.size() == 0 && !disp_valid, "R9 all three dispatched in order",
        exp_q.size(), 0);

    // R10: destroy dispatched C frees entry 2, lowest free reused
    destroy(fp_exp(2));
    sched(1, 32'h500, 1);   expect_ack("R10 freed slot reused", 2);

    // R4: frame too large, then table full
    sched(1, 32'h777, 6'(SLOT + 1));
    chk(sched_err && !sched_ack, "R4 count above slot", {sched_err, sched_ack}, 2'b10);
    for (int k = 4; k < 8; k++) begin
      sched(1, 32'h600 + 32'(k), 1);
      expect_ack("R4 filling table", k);
    end
    sched(1, 32'h888, 1);
    chk(sched_err && !sched_ack, "R4 table full", {sched_err, sched_ack}, 2'b10);

    // R6: release D and E by their writes
    fwrite(fp_exp(3), 4'd0, 32'h7);
    exp_q.push_back({32'h400, fp_exp(3)});
    fwrite(fp_exp(2), 4'd0, 32'h8);
    exp_q.push_back({32'h500, fp_exp(2)});
    repeat (6) @(negedge clk);
    #5;
    chk(exp_q.size() == 0, "R6 released threads dispatched", exp_q.size(), 0);

    finish_run();
  end
endmodule